// File: doc/BRIEF.md
# Skip-Symbol Rate-Match FIFO

This block sits in a serial receiver between the recovered clock that delivers line symbols and the local clock that consumes them. The two clocks run at nearly the same rate, but not at exactly the same rate. The block absorbs the difference by editing the stream of a programmable 10-bit filler ("skip") symbol.

When the buffer runs too full, an incoming skip symbol is discarded instead of being stored. When the buffer runs too lean, the read side emits the most recent skip symbol a second time instead of popping a new entry. Each edit is reported on the read clock with a one-cycle pulse: one flag for removals and one for additions. A level flag shows that the buffer is at or below its low mark.

By default, two edits of the same kind may not follow each other directly. A chaining input lifts that rule. When the datapath is configured for two symbols per word, a second input forces chaining on. Line decoding, word alignment and byte ordering are handled elsewhere.

Top module: `skip_rate_fifo`

## Requirements
- R1: While either reset is held and in the first read cycle after release with nothing written, `rdValid`, `rdInserted` and `rdDeleted` are low and `rdEmpty` is high.
- R2: `rdEmpty` is high whenever the read-side occupancy is at or below LOW_MARK (5 symbols) and stays high for as long as that holds; it is low above it.
- R3: A valid incoming symbol equal to `skipSym` is discarded when the write-side occupancy is at or above HIGH_MARK (12); every discarded symbol produces exactly one single-cycle pulse on `rdDeleted`; no symbol is discarded while occupancy stays below HIGH_MARK.
- R4: A skip is added only when the read-side occupancy is at or below LOW_MARK and the last symbol delivered was `skipSym`. In that cycle `rdSym` repeats `skipSym`, `rdValid` is high, no entry is consumed, and `rdInserted` is high for exactly that one read cycle.
- R5: With `chainEn` and `wideMode` both low, `rdInserted` is never high in two consecutive read cycles, and two consecutive valid incoming skip symbols are never both discarded.
- R6: With `chainEn` high, or with `wideMode` high regardless of `chainEn`, additions (and removals) may occur in consecutive cycles.
- R7: Every symbol other than `skipSym` written with `wrValid` high leaves on `rdSym` exactly once and in write order.
- R8: A write cycle with `wrValid` low stores nothing.
- R9: When the buffer holds no entry and no skip is added, `rdValid` is low and `rdSym` holds its previous value.
- R10: Once the buffer has drained, the number of `skipSym` symbols delivered equals the number of skips written, minus the `rdDeleted` pulses, plus the `rdInserted` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Recovered (write-side) clock |
| wrRstN | input | 1 | Asynchronous active-low reset, write side |
| wrSym | input | 10 | Incoming line symbol |
| wrValid | input | 1 | `wrSym` carries a symbol this cycle |
| rdClk | input | 1 | Local (read-side) clock |
| rdRstN | input | 1 | Asynchronous active-low reset, read side |
| skipSym | input | 10 | Filler symbol that may be added or removed; static during operation |
| chainEn | input | 1 | Allows consecutive additions or removals |
| wideMode | input | 1 | Two-symbols-per-word configuration; forces chaining on |
| rdSym | output | 10 | Outgoing symbol |
| rdValid | output | 1 | `rdSym` carries a symbol this cycle |
| rdEmpty | output | 1 | Read-side occupancy at or below the low mark |
| rdInserted | output | 1 | One-cycle pulse per added skip |
| rdDeleted | output | 1 | One-cycle pulse per removed skip |

## Verification
The bench runs the two clocks at several offsets, both faster and slower writers, so that the occupancy settles near each threshold. A scoreboard then tracks every data symbol and counts every skip.

- A design that let a removal or an addition touch a data symbol would reorder or lose entries, and the order check would report it.
- A design whose edit pulses were merged or doubled would break the skip balance that is computed at the end.
- Adjacent additions are counted with chaining off, with chaining on, and with only the wide-mode input set. A design that ignored either enable would either show adjacent additions where none are allowed or never show any where they are required.
- Idle write slots and drain-to-empty show whether a design stores junk or fails to hold its output when starved.

// File: rtl/skip_fifo_pkg.sv
`timescale 1ns/1ps
package skip_fifo_pkg;

  // Strobes issued by the control to the datapath in one cycle of each domain.
  typedef struct packed {
    logic push;        // write side: store wrSym
    logic drop;        // write side: discard wrSym (skip removal)
    logic pop;         // read side: consume head entry
    logic repeatSkip;  // read side: emit skipSym again
    logic ackDel;      // read side: one removal reported
  } fifoStrobes_t;

endpackage

// File: rtl/skip_fifo_sync.sv
`timescale 1ns/1ps
module skip_fifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= '0;
    end else begin
      stageQ[0] <= d;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign q = stageQ[STAGES-1];

endmodule

// File: rtl/skip_fifo_dp.sv
`timescale 1ns/1ps
module skip_fifo_dp
  import skip_fifo_pkg::*;
#(
  parameter int SYM_W       = 10,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic [SYM_W-1:0]  wrSym,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic [SYM_W-1:0]  skipSym,
  input  fifoStrobes_t      stb,
  output logic [ADDR_W:0]   wrOcc,
  output logic              wrIsSkip,
  output logic [ADDR_W:0]   rdOcc,
  output logic              headIsSkip,
  output logic              delPending,
  output logic [SYM_W-1:0]  outSym
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [SYM_W-1:0] mem [DEPTH];

  logic [PTR_W-1:0] wrPtr, wrGray, delCnt, delGray;
  logic [PTR_W-1:0] rdPtr, rdGray, delSeen;
  logic [PTR_W-1:0] rdGrayAtWr, wrGrayAtRd, delGrayAtRd;

  // ---------------- write domain ----------------
  always_ff @(posedge wrClk) begin
    if (stb.push) mem[wrPtr[ADDR_W-1:0]] <= wrSym;
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrPtr   <= '0;
      wrGray  <= '0;
      delCnt  <= '0;
      delGray <= '0;
    end else begin
      if (stb.push) begin
        wrPtr  <= wrPtr + PTR_W'(1);
        wrGray <= toGray(wrPtr + PTR_W'(1));
      end
      if (stb.drop) begin
        delCnt  <= delCnt + PTR_W'(1);
        delGray <= toGray(delCnt + PTR_W'(1));
      end
    end
  end

  skip_fifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) rdToWr_i (
    .clk(wrClk), .rstN(wrRstN), .d(rdGray), .q(rdGrayAtWr)
  );

  assign wrOcc    = wrPtr - fromGray(rdGrayAtWr);
  assign wrIsSkip = (wrSym == skipSym);

  // ---------------- read domain ----------------
  skip_fifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) wrToRd_i (
    .clk(rdClk), .rstN(rdRstN), .d(wrGray), .q(wrGrayAtRd)
  );

  skip_fifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) delToRd_i (
    .clk(rdClk), .rstN(rdRstN), .d(delGray), .q(delGrayAtRd)
  );

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdPtr   <= '0;
      rdGray  <= '0;
      delSeen <= '0;
      outSym  <= '0;
    end else begin
      if (stb.pop) begin
        rdPtr  <= rdPtr + PTR_W'(1);
        rdGray <= toGray(rdPtr + PTR_W'(1));
        outSym <= mem[rdPtr[ADDR_W-1:0]];
      end else if (stb.repeatSkip) begin
        outSym <= skipSym;
      end
      if (stb.ackDel) delSeen <= delSeen + PTR_W'(1);
    end
  end

  assign rdOcc      = fromGray(wrGrayAtRd) - rdPtr;
  assign headIsSkip = (mem[rdPtr[ADDR_W-1:0]] == skipSym);
  assign delPending = (fromGray(delGrayAtRd) != delSeen);

endmodule

// File: rtl/skip_fifo_ctl.sv
`timescale 1ns/1ps
module skip_fifo_ctl
  import skip_fifo_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int HIGH_MARK = 12,
  parameter int LOW_MARK  = 5
) (
  input  logic            wrClk,
  input  logic            wrRstN,
  input  logic            wrValid,
  input  logic            wrIsSkip,
  input  logic [ADDR_W:0] wrOcc,
  input  logic            rdClk,
  input  logic            rdRstN,
  input  logic [ADDR_W:0] rdOcc,
  input  logic            headIsSkip,
  input  logic            delPending,
  input  logic            chainEn,
  input  logic            wideMode,
  output fifoStrobes_t    stb,
  output logic            rdValid,
  output logic            rdEmpty,
  output logic            rdInserted,
  output logic            rdDeleted
);

  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] HIGH_V = PTR_W'(HIGH_MARK);
  localparam logic [PTR_W-1:0] LOW_V  = PTR_W'(LOW_MARK);
  localparam logic [PTR_W-1:0] FULL_V = PTR_W'(DEPTH);

  logic chainOn;
  logic dropNow, pushNow, repNow, popNow;
  logic lastDrop, lastRep, lastSkip;

  always_comb begin
    chainOn = chainEn | wideMode;
    dropNow = wrValid && wrIsSkip && (wrOcc >= HIGH_V) && (chainOn || !lastDrop);
    pushNow = wrValid && !dropNow && (wrOcc < FULL_V);
    repNow  = (rdOcc <= LOW_V) && lastSkip && (chainOn || !lastRep);
    popNow  = !repNow && (rdOcc != '0);
    stb.push       = pushNow;
    stb.drop       = dropNow;
    stb.pop        = popNow;
    stb.repeatSkip = repNow;
    stb.ackDel     = delPending;
  end

  // write side: remember whether the previous valid symbol was removed
  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) lastDrop <= 1'b0;
    else if (wrValid) lastDrop <= dropNow;
  end

  // read side: flags and history
  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      lastRep    <= 1'b0;
      lastSkip   <= 1'b0;
      rdValid    <= 1'b0;
      rdInserted <= 1'b0;
      rdDeleted  <= 1'b0;
    end else begin
      lastRep    <= repNow;
      if (popNow) lastSkip <= headIsSkip;
      rdValid    <= repNow || popNow;
      rdInserted <= repNow;
      rdDeleted  <= delPending;
    end
  end

  assign rdEmpty = (rdOcc <= LOW_V);

endmodule

// File: rtl/skip_rate_fifo.sv
`timescale 1ns/1ps
module skip_rate_fifo
  import skip_fifo_pkg::*;
#(
  parameter int SYM_W       = 10,
  parameter int ADDR_W      = 4,
  parameter int HIGH_MARK   = 12,
  parameter int LOW_MARK    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             wrClk,
  input  logic             wrRstN,
  input  logic [SYM_W-1:0] wrSym,
  input  logic             wrValid,
  input  logic             rdClk,
  input  logic             rdRstN,
  input  logic [SYM_W-1:0] skipSym,
  input  logic             chainEn,
  input  logic             wideMode,
  output logic [SYM_W-1:0] rdSym,
  output logic             rdValid,
  output logic             rdEmpty,
  output logic             rdInserted,
  output logic             rdDeleted
);

  fifoStrobes_t    stb;
  logic [ADDR_W:0] wrOcc, rdOcc;
  logic            wrIsSkip, headIsSkip, delPending;

  skip_fifo_ctl #(
    .ADDR_W(ADDR_W), .HIGH_MARK(HIGH_MARK), .LOW_MARK(LOW_MARK)
  ) ctl_i (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrValid(wrValid), .wrIsSkip(wrIsSkip),
    .wrOcc(wrOcc), .rdClk(rdClk), .rdRstN(rdRstN), .rdOcc(rdOcc),
    .headIsSkip(headIsSkip), .delPending(delPending), .chainEn(chainEn),
    .wideMode(wideMode), .stb(stb), .rdValid(rdValid), .rdEmpty(rdEmpty),
    .rdInserted(rdInserted), .rdDeleted(rdDeleted)
  );

  skip_fifo_dp #(
    .SYM_W(SYM_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrSym(wrSym), .rdClk(rdClk),
    .rdRstN(rdRstN), .skipSym(skipSym), .stb(stb), .wrOcc(wrOcc),
    .wrIsSkip(wrIsSkip), .rdOcc(rdOcc), .headIsSkip(headIsSkip),
    .delPending(delPending), .outSym(rdSym)
  );

endmodule

// File: rtl/skip_rate_fifo_chk.sv
`timescale 1ns/1ps
module skip_rate_fifo_chk #(
  parameter int SYM_W = 10
) (
  input logic             rdClk,
  input logic             rdRstN,
  input logic [SYM_W-1:0] rdSym,
  input logic             rdValid,
  input logic             rdEmpty,
  input logic             rdInserted,
  input logic [SYM_W-1:0] skipSym,
  input logic             chainEn,
  input logic             wideMode
);

  // R4: an added symbol is a valid copy of the skip symbol
  a_r4_repeat_is_skip: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdInserted |-> (rdValid && rdSym == skipSym));

  // R4: an addition follows a delivered skip
  a_r4_follows_skip: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdInserted |-> ($past(rdSym) == skipSym));

  // R4: an addition is only decided while at or below the low mark
  a_r4_only_when_lean: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdInserted |-> $past(rdEmpty));

  // R5: no adjacent additions without chaining
  a_r5_no_adjacent_add: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdInserted |=> !(rdInserted && !(chainEn || wideMode)));

  // R9: output symbol holds while nothing is delivered
  a_r9_idle_holds: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !rdValid |-> $stable(rdSym));

endmodule

bind skip_rate_fifo skip_rate_fifo_chk #(.SYM_W(SYM_W)) chk_i (
  .rdClk(rdClk), .rdRstN(rdRstN), .rdSym(rdSym), .rdValid(rdValid),
  .rdEmpty(rdEmpty), .rdInserted(rdInserted), .skipSym(skipSym),
  .chainEn(chainEn), .wideMode(wideMode)
);

// File: tb/skip_rate_fifo_tb_top.sv
`timescale 1ns/1ps
module skip_rate_fifo_tb_top;

  localparam logic [9:0] SKIP = 10'h17C;

  logic       wrClk = 1'b0, rdClk = 1'b0;
  logic       wrRstN = 1'b0, rdRstN = 1'b0;
  logic [9:0] wrSym = '0;
  logic       wrValid = 1'b0;
  logic       chainEn = 1'b0, wideMode = 1'b0;
  logic [9:0] rdSym;
  logic       rdValid, rdEmpty, rdInserted, rdDeleted;
  real        wrHalf = 2.0;

  skip_rate_fifo dut_i (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrSym(wrSym), .wrValid(wrValid),
    .rdClk(rdClk), .rdRstN(rdRstN), .skipSym(SKIP), .chainEn(chainEn),
    .wideMode(wideMode), .rdSym(rdSym), .rdValid(rdValid), .rdEmpty(rdEmpty),
    .rdInserted(rdInserted), .rdDeleted(rdDeleted)
  );

  always #2 rdClk = ~rdClk;            // 250 MHz read clock
  always #(wrHalf) wrClk = ~wrClk;     // write clock, offset per phase

  int nChecks = 0, nErrors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- scoreboard ----------------
  logic [9:0] dataQ[$];
  bit   monitorOn = 1'b0;
  int   ordErr, dataIn, dataOut, skipIn, skipOut, insCnt, delCnt;
  int   insSymErr, consecIns, insNotLean;
  bit   sawFull;
  bit   prevIns, prevEmpty;
  logic [9:0] prevSym;

  always @(negedge rdClk) begin
    if (monitorOn) begin
      if (rdInserted) begin
        insCnt++;
        if (!rdValid || rdSym != SKIP || prevSym != SKIP) insSymErr++;
        if (prevIns) consecIns++;
        if (!prevEmpty) insNotLean++;
      end
      if (rdDeleted) delCnt++;
      if (rdValid) begin
        if (rdSym == SKIP) skipOut++;
        else begin
          dataOut++;
          if (dataQ.size() == 0) ordErr++;
          else if (dataQ[0] != rdSym) begin ordErr++; void'(dataQ.pop_front()); end
          else void'(dataQ.pop_front());
        end
      end
      if (!rdEmpty) sawFull = 1'b1;
      prevIns   = rdInserted;
      prevEmpty = rdEmpty;
      prevSym   = rdSym;
    end
  end

  task automatic runPhase(input string name, input bit chain, input bit wide,
                          input real half, input int nSym, input int period,
                          input int run, input bit gaps, input bit fast);
    logic [9:0] lastData;
    int dataVal;
    wrHalf = half; chainEn = chain; wideMode = wide;
    wrValid = 1'b0; wrRstN = 1'b0; rdRstN = 1'b0; monitorOn = 1'b0;
    repeat (6) @(negedge rdClk);
    dataQ.delete();
    ordErr = 0; dataIn = 0; dataOut = 0; skipIn = 0; skipOut = 0;
    insCnt = 0; delCnt = 0; insSymErr = 0; consecIns = 0; insNotLean = 0;
    sawFull = 1'b0; prevIns = 1'b0; prevEmpty = 1'b1; prevSym = '0;
    wrRstN = 1'b1; rdRstN = 1'b1;
    @(negedge rdClk);
    // R1: idle state after reset
    check({rdValid, rdInserted, rdDeleted, rdEmpty} == 4'b0001, "R1",
          {name, " reset state"}, {rdValid, rdInserted, rdDeleted, rdEmpty}, 1);
    monitorOn = 1'b1;
    dataVal = 0; lastData = '0;
    for (int k = 0; k < nSym + 8; k++) begin
      @(negedge wrClk);
      if (gaps && (k % 5 == 4) && k < nSym) begin
        wrValid = 1'b0; wrSym = 10'h3FF;      // R8: must not be stored
      end else begin
        wrValid = 1'b1;
        if (k < nSym && (k % period) < run) begin
          wrSym = SKIP; skipIn++;
        end else begin
          wrSym = 10'(dataVal % 256);
          lastData = wrSym;
          dataQ.push_back(wrSym); dataIn++; dataVal++;
        end
      end
    end
    @(negedge wrClk);
    wrValid = 1'b0;
    repeat (300) @(negedge rdClk);
    monitorOn = 1'b0;

    check(ordErr == 0, "R7", {name, " order mismatches"}, ordErr, 0);
    check(dataOut == dataIn, "R7", {name, " data count"}, dataOut, dataIn);
    check(skipOut == skipIn - delCnt + insCnt, "R10", {name, " skip balance"},
          skipOut, skipIn - delCnt + insCnt);
    check(insSymErr == 0, "R4", {name, " added symbol not a repeated skip"}, insSymErr, 0);
    check(insNotLean == 0, "R4", {name, " addition above low mark"}, insNotLean, 0);
    check(rdEmpty == 1'b1, "R2", {name, " lean flag after drain"}, rdEmpty, 1);
    check({rdValid, rdSym} == {1'b0, lastData}, "R9", {name, " idle output after drain"},
          {rdValid, rdSym}, {1'b0, lastData});
    if (!(chain || wide))
      check(consecIns == 0, "R5", {name, " adjacent additions"}, consecIns, 0);
    else if (!fast)
      check(consecIns > 0, "R6", {name, " adjacent additions seen"}, consecIns, 1);
    if (fast) begin
      check(sawFull, "R2", {name, " lean flag dropped when filled"}, sawFull, 1);
      check(delCnt > 0, "R3", {name, " removals under fast writer"}, delCnt, 1);
    end else begin
      check(delCnt == 0, "R3", {name, " no removals below high mark"}, delCnt, 0);
      check(insCnt > 0, "R4", {name, " additions under slow writer"}, insCnt, 1);
    end
    if (gaps)
      check(ordErr == 0 && dataOut == dataIn, "R8", {name, " idle write slots"},
            dataOut, dataIn);
  endtask

  initial begin
    runPhase("fast_nochain",  1'b0, 1'b0, 1.8, 3000, 4, 1, 1'b0, 1'b1);
    runPhase("slow_chain",    1'b1, 1'b0, 2.2, 3000, 8, 3, 1'b0, 1'b0);
    runPhase("slow_wide",     1'b0, 1'b1, 2.2, 3000, 8, 3, 1'b0, 1'b0);
    runPhase("slow_nochain",  1'b0, 1'b0, 2.2, 3000, 8, 3, 1'b0, 1'b0);
    runPhase("fast_gaps",     1'b1, 1'b0, 1.5, 3000, 6, 3, 1'b1, 1'b1);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  int wdCycles = 0;
  always @(posedge rdClk) begin
    wdCycles++;
    if (wdCycles > 150000 && !done) begin
      done = 1'b1;
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", wdCycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

endmodule